// File: doc/BRIEF.md
# Serial Port Register File with Interrupt Prioritiser

This block is the host-visible register set of a classic byte-wide serial port, together with the logic that raises its interrupt. A host reaches eight byte registers through a 3-bit address with separate read and write strobes. On the line side, the block takes received bytes and break events through a valid/ready handshake. It presents each transmitted byte as a single-cycle valid pulse. Bit shifting, baud timing, parity and FIFOs belong to other blocks. The 16-bit divisor is only stored and read back.

The block keeps the divisor latch, the interrupt enable, line control, modem control and scratch registers. It derives the interrupt identification, line status and modem status values. Two interrupt causes exist. Received data outranks transmit-holding-empty. The transmit cause is a hidden flag: writing a byte to send sets it, and an identification read that reports that cause clears it. A loopback bit in modem control routes the modem output controls back into the modem status bits.

Top module: `serial_port_regs`

## Requirements
- R1: After reset, line status (address 5) reads 0x60, identification (address 2) reads 0x01, `irq` is low and `rx_ready` is high.
- R2: With line control bit 7 set, address 0 reads and writes the divisor low byte and address 1 the high byte. Accesses in this mode neither send a byte nor change the enable register.
- R3: With line control bit 7 clear, address 1 writes the enable register from data bits 3:0 and reads it back with bits 7:4 zero. Bit 0 enables received data and bit 1 enables transmit empty.
- R4: Identification reads 0x04 when data is ready and enable bit 0 is set. Otherwise it reads 0x02 when the transmit flag is set and enable bit 1 is set. Otherwise it reads 0x01.
- R5: `irq` is high exactly when identification differs from 0x01, and it follows the state one clock later.
- R6: Writing address 0 with line control bit 7 clear sets the transmit flag. One clock later, `tx_valid` pulses with that byte on `tx_data`. Line status still reads 0x60 afterwards.
- R7: An identification read that returns 0x02 clears the transmit flag. A read that returns any other value leaves it set.
- R8: Reading address 0 with line control bit 7 clear returns the held byte and clears line status bit 0 (ready) and bit 4 (break).
- R9: An accepted byte is held and sets status bit 0. An accepted break loads 0x00 and sets bits 0 and 4. `rx_ready` is high only while bit 0 is clear, and offers made while it is low are dropped.
- R10: With modem control bit 4 set, modem status bits 7:6 read modem control bits 3:2, bit 5 reads control bit 0, bit 4 reads control bit 1, and bits 3:0 read zero.
- R11: With modem control bit 4 clear, modem status bits 7:4 read `modem_in[3:0]` and bits 3:0 read zero.
- R12: Line control and scratch (address 7) read back as written. Modem control reads back bits 4:0 with bits 7:5 zero. Writes to addresses 2, 5 and 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_rdata | output | 8 | Read data, registered |
| rx_valid | input | 1 | Receive offer |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Offer is a break event |
| rx_ready | output | 1 | Receive holding register free |
| tx_valid | output | 1 | Transmit byte pulse |
| tx_data | output | 8 | Transmit byte |
| modem_in | input | 4 | Modem status inputs, bit 3 highest |
| irq | output | 1 | Level interrupt, registered |

## Verification
Read data, register updates, `rx_ready` and the transmit pulse all take effect on the clock edge that samples the strobe or the offer, so they are observed one edge after the stimulus. `irq` is registered from the updated state and is due one edge later than that. The bench drives inputs on falling edges. A scoreboard queues the expected read bytes and transmitted bytes and compares them on the falling edge after the capturing edge. Each interrupt check waits one extra falling edge before it samples `irq`.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int SP_DW   = 8;
  localparam int SP_AW   = 3;
  localparam int SP_DIVW = 2 * SP_DW;
  localparam int SP_MW   = 4;

  typedef enum logic [SP_AW-1:0] {
    RA_DATA = 3'd0,
    RA_IER  = 3'd1,
    RA_IIR  = 3'd2,
    RA_LCR  = 3'd3,
    RA_MCR  = 3'd4,
    RA_LSR  = 3'd5,
    RA_MSR  = 3'd6,
    RA_SCR  = 3'd7
  } reg_addr_e;

  localparam logic [SP_DW-1:0] IIR_NONE = 8'h01;
  localparam logic [SP_DW-1:0] IIR_TXE  = 8'h02;
  localparam logic [SP_DW-1:0] IIR_RXD  = 8'h04;
endpackage

// File: rtl/sp_rx_hold.sv
module sp_rx_hold
  import sp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [SP_DW-1:0] in_data,
  input  logic             in_break,
  input  logic             take,
  output logic [SP_DW-1:0] held,
  output logic             ready_flag,
  output logic             break_flag,
  output logic             can_accept
);
  logic accept;

  assign can_accept = !ready_flag;
  assign accept     = in_valid && can_accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      held       <= '0;
      ready_flag <= 1'b0;
      break_flag <= 1'b0;
    end else if (accept) begin
      held       <= in_break ? '0 : in_data;
      ready_flag <= 1'b1;
      break_flag <= in_break;
    end else if (take) begin
      ready_flag <= 1'b0;
      break_flag <= 1'b0;
    end
  end

  AST_ACCEPT_SETS_READY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && can_accept) |=> ready_flag); // R9
  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (take && !accept) |=> (!ready_flag && !break_flag)); // R8
endmodule

// File: rtl/sp_irq_arb.sv
module sp_irq_arb
  import sp_pkg::*;
(
  input  logic             data_ready,
  input  logic             tx_pending,
  input  logic             en_rx,
  input  logic             en_tx,
  output logic [SP_DW-1:0] code
);
  always_comb begin
    if (data_ready && en_rx)      code = IIR_RXD;
    else if (tx_pending && en_tx) code = IIR_TXE;
    else                          code = IIR_NONE;
  end
endmodule

// File: rtl/sp_msr_mux.sv
module sp_msr_mux
  import sp_pkg::*;
(
  input  logic             loop_en,
  input  logic [3:0]       ctrl,
  input  logic [SP_MW-1:0] pins,
  output logic [SP_DW-1:0] status
);
  logic [SP_MW-1:0] upper;

  assign upper  = loop_en ? {ctrl[3], ctrl[2], ctrl[0], ctrl[1]} : pins;
  assign status = {upper, {(SP_DW-SP_MW){1'b0}}};
endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
  import sp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SP_AW-1:0] bus_addr,
  input  logic [SP_DW-1:0] bus_wdata,
  input  logic             bus_wr,
  input  logic             bus_rd,
  output logic [SP_DW-1:0] bus_rdata,
  input  logic             rx_valid,
  input  logic [SP_DW-1:0] rx_data,
  input  logic             rx_break,
  output logic             rx_ready,
  output logic             tx_valid,
  output logic [SP_DW-1:0] tx_data,
  input  logic [SP_MW-1:0] modem_in,
  output logic             irq
);
  localparam int IER_W = 4;
  localparam int MCR_W = 5;

  logic [SP_DIVW-1:0] div_q;
  logic [IER_W-1:0]   ier_q;
  logic [SP_DW-1:0]   lcr_q;
  logic [MCR_W-1:0]   mcr_q;
  logic [SP_DW-1:0]   scr_q;
  logic               tx_pend;
  logic               irq_q;

  logic [SP_DW-1:0] rbr;
  logic             dr, bi;
  logic [SP_DW-1:0] iir_code;
  logic [SP_DW-1:0] msr_val;
  logic [SP_DW-1:0] lsr_val;
  logic [SP_DW-1:0] rd_mux;

  reg_addr_e ra;
  logic      dlab;
  logic      wr_thr, rd_rbr, rd_iir;

  assign ra     = reg_addr_e'(bus_addr);
  assign dlab   = lcr_q[SP_DW-1];
  assign wr_thr = bus_wr && (ra == RA_DATA) && !dlab;
  assign rd_rbr = bus_rd && (ra == RA_DATA) && !dlab;
  assign rd_iir = bus_rd && (ra == RA_IIR);

  sp_rx_hold u_rx (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (rx_valid),
    .in_data    (rx_data),
    .in_break   (rx_break),
    .take       (rd_rbr),
    .held       (rbr),
    .ready_flag (dr),
    .break_flag (bi),
    .can_accept (rx_ready)
  );

  sp_irq_arb u_arb (
    .data_ready (dr),
    .tx_pending (tx_pend),
    .en_rx      (ier_q[0]),
    .en_tx      (ier_q[1]),
    .code       (iir_code)
  );

  sp_msr_mux u_msr (
    .loop_en (mcr_q[4]),
    .ctrl    (mcr_q[3:0]),
    .pins    (modem_in),
    .status  (msr_val)
  );

  // transmitter is modelled as instantaneous: holding and shift both empty
  assign lsr_val = {1'b0, 1'b1, 1'b1, bi, 3'b000, dr};

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= '0;
      ier_q    <= '0;
      lcr_q    <= '0;
      mcr_q    <= '0;
      scr_q    <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= 1'b0;
      if (bus_wr) begin
        unique case (ra)
          RA_DATA: begin
            if (dlab) div_q[SP_DW-1:0] <= bus_wdata;
            else begin
              tx_valid <= 1'b1;
              tx_data  <= bus_wdata;
            end
          end
          RA_IER: begin
            if (dlab) div_q[SP_DIVW-1:SP_DW] <= bus_wdata;
            else      ier_q <= bus_wdata[IER_W-1:0];
          end
          RA_LCR:  lcr_q <= bus_wdata;
          RA_MCR:  mcr_q <= bus_wdata[MCR_W-1:0];
          RA_SCR:  scr_q <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                 tx_pend <= 1'b0;
    else if (wr_thr)                         tx_pend <= 1'b1;
    else if (rd_iir && iir_code == IIR_TXE)  tx_pend <= 1'b0;
  end

  always_comb begin
    unique case (ra)
      RA_DATA: rd_mux = dlab ? div_q[SP_DW-1:0] : rbr;
      RA_IER:  rd_mux = dlab ? div_q[SP_DIVW-1:SP_DW]
                             : {{(SP_DW-IER_W){1'b0}}, ier_q};
      RA_IIR:  rd_mux = iir_code;
      RA_LCR:  rd_mux = lcr_q;
      RA_MCR:  rd_mux = {{(SP_DW-MCR_W){1'b0}}, mcr_q};
      RA_LSR:  rd_mux = lsr_val;
      RA_MSR:  rd_mux = msr_val;
      RA_SCR:  rd_mux = scr_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_q     <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq_q <= (iir_code != IIR_NONE);
    end
  end

  assign irq = irq_q;

  AST_THR_SENDS: assert property (@(posedge clk) disable iff (rst)
    wr_thr |=> (tx_valid && tx_data == $past(bus_wdata))); // R6
  AST_TXE_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_iir && tx_pend && ier_q[1] && !(dr && ier_q[0]) && !wr_thr) |=> !tx_pend); // R7
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(ier_q[1:0] != 2'b00)); // R5
  AST_DLAB_NO_TX: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && ra == RA_DATA && dlab) |=> !tx_valid); // R2
endmodule

// File: tb/serial_port_regs_tb.sv
module serial_port_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_ready, tx_valid, irq;
  logic [7:0] tx_data;
  logic [3:0] modem_in = '0;

  int checks = 0, errors = 0;
  logic [7:0] rd_exp_q[$];
  string      rd_tag_q[$];
  logic [7:0] tx_exp_q[$];
  logic       rd_seen = 1'b0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_port_regs u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .modem_in(modem_in), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: compares results on the falling edge after the capturing edge
  always @(negedge clk) begin
    if (rd_seen) begin
      if (rd_exp_q.size() == 0) check("read-unexpected", bus_rdata, 8'hxx);
      else check(rd_tag_q.pop_front(), bus_rdata, rd_exp_q.pop_front());
    end
    if (tx_valid && !rst) begin
      if (tx_exp_q.size() == 0) check("R6 unexpected tx", tx_data, 8'hxx);
      else check("R6 tx byte", tx_data, tx_exp_q.pop_front());
    end
  end

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_exp_q.push_back(exp); rd_tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d, input logic brk);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_break = brk;
    @(negedge clk);
    rx_valid = 1'b0; rx_break = 1'b0;
  endtask

  task automatic check_irq(input logic exp, input string tag);
    @(negedge clk);
    check(tag, {7'd0, irq}, {7'd0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 rx_ready", {7'd0, rx_ready}, 8'h01);
    bus_read(3'd5, 8'h60, "R1 lsr");
    bus_read(3'd2, 8'h01, "R1 iir");
    // R12 plain registers
    bus_write(3'd7, 8'hA5); bus_read(3'd7, 8'hA5, "R12 scratch");
    bus_write(3'd3, 8'h1B); bus_read(3'd3, 8'h1B, "R12 lcr");
    bus_write(3'd4, 8'hFF); bus_read(3'd4, 8'h1F, "R12 mcr");
    bus_write(3'd4, 8'h00);
    // R2 divisor latch
    bus_write(3'd3, 8'h83);
    bus_write(3'd0, 8'h34); bus_write(3'd1, 8'h12);
    bus_read(3'd0, 8'h34, "R2 div lo");
    bus_read(3'd1, 8'h12, "R2 div hi");
    bus_write(3'd3, 8'h03);
    bus_read(3'd1, 8'h00, "R2 ier untouched");
    // R3 enable register
    bus_write(3'd1, 8'hFF); bus_read(3'd1, 8'h0F, "R3 ier mask");
    bus_write(3'd1, 8'h00);
    bus_write(3'd3, 8'h83); bus_read(3'd0, 8'h34, "R2 div kept");
    bus_write(3'd3, 8'h03);
    // R6 transmit, R7 pending survives a 0x01 read
    tx_exp_q.push_back(8'h41); bus_write(3'd0, 8'h41);
    bus_read(3'd5, 8'h60, "R6 lsr after thr");
    bus_read(3'd2, 8'h01, "R4 iir disabled");
    bus_write(3'd1, 8'h02);
    check_irq(1'b1, "R5 irq on tx pending");
    bus_read(3'd2, 8'h02, "R7 iir txe");
    check_irq(1'b0, "R5 irq after clear");
    bus_read(3'd2, 8'h01, "R7 pending cleared");
    // R4 priority
    bus_write(3'd1, 8'h03);
    tx_exp_q.push_back(8'h42); bus_write(3'd0, 8'h42);
    rx_push(8'h5A, 1'b0);
    check("R9 rx_ready low", {7'd0, rx_ready}, 8'h00);
    bus_read(3'd2, 8'h04, "R4 rx over tx");
    bus_read(3'd0, 8'h5A, "R8 rbr");
    bus_read(3'd2, 8'h02, "R7 pending kept after 0x04");
    bus_read(3'd2, 8'h01, "R4 none");
    bus_read(3'd5, 8'h60, "R8 dr cleared");
    // R9 break and dropped offers
    rx_push(8'h77, 1'b1);
    bus_read(3'd5, 8'h71, "R9 break lsr");
    bus_read(3'd0, 8'h00, "R9 break rbr");
    bus_read(3'd5, 8'h60, "R8 bi cleared");
    rx_push(8'h11, 1'b0);
    rx_push(8'h22, 1'b0);
    bus_read(3'd0, 8'h11, "R9 offer dropped");
    // R12 read-only writes ignored
    rx_push(8'h33, 1'b0);
    bus_write(3'd5, 8'h00); bus_write(3'd2, 8'hFF); bus_write(3'd6, 8'hFF);
    bus_read(3'd5, 8'h61, "R12 lsr write ignored");
    bus_read(3'd2, 8'h04, "R12 iir write ignored");
    bus_read(3'd0, 8'h33, "R12 rbr intact");
    // R11 / R10 modem status
    modem_in = 4'b1010;
    bus_read(3'd6, 8'hA0, "R11 msr pins");
    bus_write(3'd4, 8'h1B); bus_read(3'd6, 8'hB0, "R10 loop 1B");
    bus_write(3'd4, 8'h14); bus_read(3'd6, 8'h40, "R10 loop 14");
    bus_write(3'd4, 8'h13); bus_read(3'd6, 8'h30, "R10 loop 13");
    bus_write(3'd4, 8'h00); bus_read(3'd6, 8'hA0, "R11 loop off");
    // R5 irq from received data
    bus_write(3'd1, 8'h01);
    check_irq(1'b0, "R5 idle");
    rx_push(8'h99, 1'b0);
    check_irq(1'b1, "R5 irq on rx");
    bus_read(3'd0, 8'h99, "R8 rbr 99");
    check_irq(1'b0, "R5 irq drops");
    repeat (3) @(negedge clk);
    check("R6 tx queue drained", 8'(tx_exp_q.size()), 8'h00);
    check("read queue drained", 8'(rd_exp_q.size()), 8'h00);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule